// File: doc/BRIEF.md
# Manchester Transmit Serializer

This block turns a stream of octets into the single-bit transmit level of a 10 Mb/s twisted-pair link. Every octet in the stream is sent on the line: preamble, start-of-frame delimiter, payload, padding and check sequence. Each bit is Manchester-coded while it is sent, so no coded copy of the frame is stored. When the final bit has gone out, the block drives a fixed-width high pulse that marks the start of idle, then takes the line low again. A counter of system-clock cycles sets every half-bit period. The defaults of eight cycles per half-bit at a 160 MHz clock give 50 ns symbols.

Octets arrive on a valid/ready byte interface with a last-octet flag. The block keeps one holding register. That register can take the next octet while the current one is shifting out, so an upstream source that answers within one octet time never stretches a symbol. Back-pressure rules:
- `s_ready` is high only while the holding register is empty.
- An octet is taken on each clock edge where both `s_valid` and `s_ready` are high.
- While `s_valid` is high and `s_ready` is low, the source must hold `s_data` and `s_last` steady.

A plain status group reports activity and errors. `busy` is high while a frame or its idle marker is on the line, and `done` pulses once when the line is released. `len_err` and `underrun` are per-frame flags. Each is set when the idle marker begins and stays set until the next frame starts.

Top module: `manchester_tx`

## Requirements
- R1: A data bit takes two half-bit symbols of `HALF_CYC` clock cycles each. The first symbol is the complement of the bit and the second is the bit itself: a 0 is sent high then low, a 1 low then high.
- R2: Within an octet, bit 0 (the least significant) goes out first. Octets go out in the order they were accepted.
- R3: No cycle is added or lost between octets, the first octet included. A frame of n octets keeps `busy` high for exactly n·16·`HALF_CYC` + `IDLE_HALVES`·`HALF_CYC` cycles, and every line change falls on the half-bit grid measured from the frame start.
- R4: Right after the last half-bit symbol, the line is high for `IDLE_HALVES`·`HALF_CYC` cycles (default 5 half-bits, 250 ns). It then goes low.
- R5: The line is low whenever no frame is active. A frame starts on the clock edge after its first octet is in the holding register, so a leading 1 bit shows low first and has its first rising edge at mid-bit.
- R6: A frame whose octet count is below `MIN_LEN` or above `MAX_LEN` (defaults 72 and 1530) is still sent in full. In that case `len_err` is set when its idle marker begins and stays set until the next frame starts.
- R7: `busy` is high from the first half-bit symbol to the end of the idle marker. In the one cycle where the line returns low, `busy` is low and `done` is high.
- R8: `s_ready` equals "holding register empty". An accepted octet drops `s_ready` on the next cycle, and `s_ready` rises again when the octet is moved into the shifter.
- R9: If a non-last octet finishes and no next octet is held, the frame is aborted at that bit boundary. The idle marker begins at once, and `underrun` is set until the next frame starts.
- R10: After reset the line is low, `busy`, `done`, `len_err` and `underrun` are low, and `s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_data | input | 8 | Frame octet |
| s_valid | input | 1 | `s_data`/`s_last` are valid |
| s_last | input | 1 | This octet ends the frame |
| s_ready | output | 1 | Holding register is empty and takes an octet this edge |
| tx_line | output | 1 | Manchester-coded transmit level |
| busy | output | 1 | Frame or idle marker on the line |
| done | output | 1 | One-cycle pulse when the line returns to idle |
| len_err | output | 1 | Last frame's octet count was out of range |
| underrun | output | 1 | Last frame was aborted because no octet was held |

## Verification
The octet values used are all-zeros, all-ones, alternating 0x55 and an asymmetric pattern such as 0xD5 or 0xA3:
- All-zeros and all-ones octets give the longest runs without a mid-bit reversal between bits, so they expose a swapped half-symbol order.
- The alternating and asymmetric octets show a reversed bit order and any stretched symbol at an octet boundary.

Frames of one below, exactly at, and one above each length limit tell the limit comparisons apart. A frame whose source stops supplying octets separates the underrun abort from a normal end. Two frames queued back to back show that an octet prefetched during the idle marker waits for the line to go low.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_MARK
  } mtx_state_e;

  // first half of a coded bit is the complement of the bit
  function automatic logic lead_half(input logic b);
    return ~b;
  endfunction

endpackage

// File: rtl/mtx_prefetch.sv
module mtx_prefetch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  input  logic         in_last,
  output logic         in_ready,
  input  logic         take,
  output logic         held,
  output logic [W-1:0] held_data,
  output logic         held_last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held      <= 1'b0;
      held_data <= '0;
      held_last <= 1'b0;
    end else if (in_valid && !held) begin
      held      <= 1'b1;
      held_data <= in_data;
      held_last <= in_last;
    end else if (take) begin
      held <= 1'b0;
    end
  end

  assign in_ready = !held;

endmodule

// File: rtl/mtx_halfbit_timer.sv
module mtx_halfbit_timer #(
  parameter int HALF_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic half_end
);

  generate
    if (HALF_CYC == 1) begin : g_every_cycle
      assign half_end = run;
    end else begin : g_counter
      localparam int CW = $clog2(HALF_CYC);
      localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (!run)        cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
      end

      assign half_end = run && (cnt == LAST);
    end
  endgenerate

endmodule

// File: rtl/mtx_len_check.sv
module mtx_len_check #(
  parameter int MIN_LEN = 72,
  parameter int MAX_LEN = 1530
) (
  input  logic clk,
  input  logic rst_n,
  input  logic first,
  input  logic next,
  output logic bad
);

  localparam int LEN_W = $clog2(MAX_LEN + 2);
  localparam logic [LEN_W-1:0] SAT = LEN_W'(MAX_LEN + 1);

  logic [LEN_W-1:0] cnt;
  logic             short_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (first)               cnt <= LEN_W'(1);
    else if (next && cnt != SAT)  cnt <= cnt + 1'b1;
  end

  generate
    if (MIN_LEN > 1) begin : g_short
      assign short_f = cnt < LEN_W'(MIN_LEN);
    end else begin : g_no_short
      assign short_f = 1'b0;
    end
  endgenerate

  assign bad = short_f || (cnt > LEN_W'(MAX_LEN));

endmodule

// File: rtl/manchester_tx.sv
module manchester_tx
  import mtx_pkg::*;
#(
  parameter int HALF_CYC    = 8,
  parameter int IDLE_HALVES = 5,
  parameter int MIN_LEN     = 72,
  parameter int MAX_LEN     = 1530
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  output logic       tx_line,
  output logic       busy,
  output logic       done,
  output logic       len_err,
  output logic       underrun
);

  localparam int MK_W = $clog2(IDLE_HALVES + 1);
  localparam logic [MK_W-1:0] MK_LAST = MK_W'(IDLE_HALVES - 1);

  mtx_state_e st;
  logic [7:0] sh;
  logic       cur_last;
  logic [3:0] hidx;
  logic [MK_W-1:0] mcnt;
  logic       line_q, done_q, len_err_q, und_q;

  logic       held, held_last, take, half_end, len_bad;
  logic [7:0] held_data;
  logic       start, chain, byte_end;

  assign byte_end = (st == ST_DATA) && half_end && (hidx == 4'hF);
  assign start    = (st == ST_IDLE) && held;
  assign chain    = byte_end && !cur_last && held;
  assign take     = start || chain;

  mtx_prefetch #(.W(8)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .in_data(s_data), .in_valid(s_valid), .in_last(s_last), .in_ready(s_ready),
    .take(take), .held(held), .held_data(held_data), .held_last(held_last)
  );

  mtx_halfbit_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(st != ST_IDLE), .half_end(half_end)
  );

  mtx_len_check #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_len (
    .clk(clk), .rst_n(rst_n), .first(start), .next(chain), .bad(len_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      sh        <= '0;
      cur_last  <= 1'b0;
      hidx      <= '0;
      mcnt      <= '0;
      line_q    <= 1'b0;
      done_q    <= 1'b0;
      len_err_q <= 1'b0;
      und_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (held) begin
            st        <= ST_DATA;
            sh        <= held_data;
            cur_last  <= held_last;
            hidx      <= '0;
            line_q    <= lead_half(held_data[0]);
            len_err_q <= 1'b0;
            und_q     <= 1'b0;
          end
        end
        ST_DATA: begin
          if (half_end) begin
            if (hidx != 4'hF) begin
              hidx <= hidx + 1'b1;
              if (!hidx[0]) begin
                line_q <= sh[0];
              end else begin
                sh     <= {1'b0, sh[7:1]};
                line_q <= lead_half(sh[1]);
              end
            end else if (cur_last) begin
              st        <= ST_MARK;
              mcnt      <= '0;
              line_q    <= 1'b1;
              len_err_q <= len_bad;
            end else if (held) begin
              sh       <= held_data;
              cur_last <= held_last;
              hidx     <= '0;
              line_q   <= lead_half(held_data[0]);
            end else begin
              st     <= ST_MARK;
              mcnt   <= '0;
              line_q <= 1'b1;
              und_q  <= 1'b1;
            end
          end
        end
        ST_MARK: begin
          if (half_end) begin
            if (mcnt == MK_LAST) begin
              st     <= ST_IDLE;
              line_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              mcnt <= mcnt + 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign tx_line  = line_q;
  assign busy     = (st != ST_IDLE);
  assign done     = done_q;
  assign len_err  = len_err_q;
  assign underrun = und_q;

endmodule

// File: rtl/mtx_checker.sv
module mtx_checker #(
  parameter int HALF_CYC = 8
) (
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_ready,
  input logic tx_line,
  input logic busy,
  input logic done
);

  int ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ph <= 0;
    else if (!busy)             ph <= 0;
    else if (ph == HALF_CYC-1)  ph <= 0;
    else                        ph <= ph + 1;
  end

  // R3: line changes only on the half-bit grid of the active frame
  a_r3_edges_on_grid: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (tx_line != $past(tx_line))) |-> (ph == 0));

  // R5: idle line is low
  a_r5_line_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_line);

  // R7: done lasts a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: done only where busy has just dropped
  a_r7_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R4: end of the marker takes the line low with done
  a_r4_marker_ends_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && !tx_line));

  // R8: an accepted octet fills the holding slot
  a_r8_slot_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

endmodule

bind manchester_tx mtx_checker #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .tx_line(tx_line), .busy(busy), .done(done)
);

// File: tb/manchester_tx_tb_top.sv
`timescale 1ns/1ps
module manchester_tx_tb_top;

  localparam int H     = 8;
  localparam int IH    = 5;
  localparam int MIN_L = 4;
  localparam int MAX_L = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] s_data = '0;
  logic       s_valid = 1'b0;
  logic       s_last = 1'b0;
  logic       s_ready, tx_line, busy, done, len_err, underrun;

  int nvec = 0;
  int nfail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  manchester_tx #(.HALF_CYC(H), .IDLE_HALVES(IH), .MIN_LEN(MIN_L), .MAX_LEN(MAX_L)) dut_i (
    .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
    .s_ready(s_ready), .tx_line(tx_line), .busy(busy), .done(done),
    .len_err(len_err), .underrun(underrun)
  );

  // ---------------- behavioural reference ----------------
  int         q_data[$];
  bit         q_last[$];
  int         m_st;      // 0 idle, 1 data, 2 marker
  int         m_t;
  logic [7:0] m_cur;
  bit         m_curlast;
  int         m_cnt;
  logic       m_line, m_done, m_len, m_und;

  always @(posedge clk) begin : model
    bit acc;
    int h;
    if (!rst_n) begin
      q_data.delete(); q_last.delete();
      m_st = 0; m_t = 0; m_cur = 0; m_curlast = 0; m_cnt = 0;
      m_line = 0; m_done = 0; m_len = 0; m_und = 0;
    end else begin
      acc = s_valid && (q_data.size() == 0);
      m_done = 0;
      case (m_st)
        0: if (q_data.size() > 0) begin
          m_cur = 8'(q_data.pop_front()); m_curlast = q_last.pop_front();
          m_cnt = 1; m_len = 0; m_und = 0; m_st = 1; m_t = 0;
          m_line = ~m_cur[0];
        end
        1: begin
          m_t++;
          if (m_t % H == 0) begin
            h = m_t / H;
            if (h < 16) begin
              m_line = (h % 2 == 1) ? m_cur[h/2] : ~m_cur[h/2];
            end else if (m_curlast) begin
              m_len = (m_cnt < MIN_L) || (m_cnt > MAX_L);
              m_st = 2; m_t = 0; m_line = 1;
            end else if (q_data.size() > 0) begin
              m_cur = 8'(q_data.pop_front()); m_curlast = q_last.pop_front();
              m_cnt++; m_t = 0; m_line = ~m_cur[0];
            end else begin
              m_und = 1; m_st = 2; m_t = 0; m_line = 1;
            end
          end
        end
        default: begin
          m_t++;
          if (m_t == IH * H) begin
            m_st = 0; m_line = 0; m_done = 1;
          end
        end
      endcase
      if (acc) begin
        q_data.push_back(int'(s_data));
        q_last.push_back(s_last);
      end
    end
  end

  task automatic check(input int act, input int exp, input string tag, input string what);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the reference, away from the clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(int'(tx_line), int'(m_line),
            (m_st == 1) ? "R1/R2/R3" : (m_st == 2) ? "R4" : "R5", "tx_line");
      check(int'(busy), int'(m_st != 0), "R7", "busy");
      check(int'(done), int'(m_done), "R7", "done");
      check(int'(s_ready), int'(q_data.size() == 0), "R8", "s_ready");
      check(int'(len_err), int'(m_len), "R6", "len_err");
      check(int'(underrun), int'(m_und), "R9", "underrun");
    end
  end

  // busy-length and done-count monitor
  int bcnt = 0;
  int last_busy = 0;
  int ndone = 0;
  always @(posedge clk) begin
    #1;
    if (done) begin
      last_busy = bcnt; bcnt = 0; ndone++;
    end else if (busy) begin
      bcnt++;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 60000) begin
      nfail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  logic [7:0] fq[$];

  task automatic push(input logic [7:0] b, input logic l);
    @(negedge clk);
    s_data = b; s_last = l; s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    #1 s_valid = 1'b0;
  endtask

  task automatic send_fq(input bit end_last);
    foreach (fq[i]) push(fq[i], end_last && (i == fq.size() - 1));
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!done) @(negedge clk);
  endtask

  task automatic frame_normal(input int n, input int exp_len);
    fq.delete();
    for (int i = 0; i < n; i++) fq.push_back(8'(8'hA3 ^ (i * 37)));
    send_fq(1);
    wait_done();
    check(last_busy, n * 16 * H + IH * H, "R3", "busy length");
    check(int'(len_err), exp_len, "R6", "length flag");
    check(int'(underrun), 0, "R9", "no underrun");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(int'(tx_line), 0, "R10", "reset line");
    check(int'(busy), 0, "R10", "reset busy");
    check(int'(done), 0, "R10", "reset done");
    check(int'(s_ready), 1, "R10", "reset ready");
    check(int'(len_err) + int'(underrun), 0, "R10", "reset flags");

    // R1 R2: extreme and alternating patterns at minimum length
    fq = '{8'h00, 8'hFF, 8'h55, 8'hD5};
    send_fq(1);
    wait_done();
    check(last_busy, 4 * 16 * H + IH * H, "R3", "busy length 4 octets");
    check(int'(len_err), 0, "R6", "at minimum");
    check(int'(tx_line), 0, "R4", "line low after marker");

    // R5: leading 1 bit shows low, rises at mid-bit
    fq = '{8'h55, 8'h55, 8'h55, 8'h55, 8'h55, 8'hD5};
    fork
      send_fq(1);
      begin
        @(negedge clk);
        while (!busy) @(negedge clk);
        check(int'(tx_line), 0, "R5", "first half of leading 1");
        repeat (H) @(negedge clk);
        check(int'(tx_line), 1, "R5", "mid-bit rise");
      end
    join
    wait_done();
    check(last_busy, 6 * 16 * H + IH * H, "R3", "busy length 6 octets");

    // R6: length limits
    frame_normal(3, 1);
    frame_normal(10, 0);
    frame_normal(11, 1);

    // R9: source stops after two non-last octets
    push(8'h12, 1'b0);
    push(8'h34, 1'b0);
    wait_done();
    check(int'(underrun), 1, "R9", "underrun set");
    check(int'(len_err), 0, "R9", "no length flag on abort");
    check(last_busy, 2 * 16 * H + IH * H, "R9", "aborted length");
    frame_normal(4, 0);   // R9 flag cleared by next frame

    // R7 R8: two frames queued back to back
    ndone = 0;
    fq = '{8'h01, 8'h80, 8'h7E, 8'hC3, 8'h11, 8'h22, 8'h33, 8'h44};
    foreach (fq[i]) push(fq[i], (i == 3) || (i == 7));
    wait_done();
    @(negedge clk);
    while (busy || !s_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    check(ndone, 2, "R7", "done pulses for two frames");
    check(last_busy, 4 * 16 * H + IH * H, "R3", "second frame length");

    summary();
    $finish;
  end

endmodule